// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Micropipeline

The block is a self-timed first-in first-out pipeline of `DEPTH` stages. Its control is a chain of Muller C-elements. Each stage owns one C-element and one data register. The C-element of a stage has two inputs: the request coming from the stage before it, and the inverted acknowledge coming from the stage after it. Its output goes high or low only when those two inputs agree, and holds its value while they disagree. When that output changes, two things happen in the same step. The stage captures the word held by its upstream neighbour. The change then serves as the request to the next stage and as the acknowledge to the previous one.

Both channels use two-phase (transition) signalling, and a rising edge and a falling edge count the same.

- **Input side.** A producer places a word on `in_data` and toggles `in_req`. It must then wait until `in_ack` equals `in_req` before it changes the data or toggles again.
- **Output side.** A new word is announced when `out_req` differs from `out_ack`. The consumer reads `out_data` and toggles `out_ack` to release it. Back-pressure is simply the consumer withholding that toggle. Each stage stays locked, holding its word, until its downstream neighbour has taken it. This happens whatever the upstream request does.

The whole block is modelled on a fast sampling clock. Each C-element is a state bit, and a word can advance one stage per clock. Occupancy is read straight from the C-element state vector. A stage holds a word when its output differs from the acknowledge it receives. `empty` and `full` are taken from that pattern.

Top module: `micropipe_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the outputs are fixed. `in_ack` = 0, `out_req` = 0, `out_data` = 0, `empty` = 1 and `full` = 0.
- R2: The stage that receives `in_req` accepts an offered word one clock after `in_req` is sampled different from `in_ack`, provided that stage is free. `in_ack` then takes the value of `in_req`, and `in_ack` never changes to any value other than the previously sampled `in_req`.
- R3: Words leave in the order they entered. None is lost and none is repeated.
- R4: On an empty pipeline, `out_req` toggles exactly `DEPTH` clocks after the clock that first samples the toggled `in_req` (one stage per clock).
- R5: A rising and a falling transition on `in_req` or `out_ack` are equally valid events.
- R6: While `full` is 1, a pending input toggle is not acknowledged (`in_ack` stays put) until the consumer releases a word.
- R7: While `out_req` differs from `out_ack`, `out_data` and `out_req` remain stable.
- R8: `empty` is 1 exactly when no stage holds a word. `full` is 1 exactly when all `DEPTH` stages hold one. Both flags are never 1 together.
- R9: A stage whose word has not been acknowledged downstream keeps that word. With the output withheld, the word at the output is the first one written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock that updates the C-element states |
| rst_n | input | 1 | Active-low reset; clears all C-elements and data |
| in_req | input | 1 | Input request; each transition offers `in_data` |
| in_ack | output | 1 | Input acknowledge; equals `in_req` once the word is taken |
| in_data | input | DATA_W | Word offered by the producer |
| out_req | output | 1 | Output request; differs from `out_ack` while a word waits |
| out_ack | input | 1 | Output acknowledge; each transition releases the output word |
| out_data | output | DATA_W | Word at the last stage |
| empty | output | 1 | No stage holds a word |
| full | output | 1 | Every stage holds a word |

## Verification
The tests below each separate one behaviour from another that could look similar at the ports.

- **Single word into an empty pipeline, consumer silent.** This measures latency. It separates a stage-per-clock ripple from a design that skips or stalls stages.
- **Fill with the consumer withheld, then one extra request.** This shows that the locked stages hold their words and refuse further input. It also shows that the output word does not change and that the full flag rises on the exact occupancy.
- **Long stream with random gaps on both sides.** Input and output toggles arrive at random times. This drives every pattern of partial occupancy and both edge directions. The scoreboard then catches any reordering, loss or duplication.

// File: rtl/mp_pkg.sv
package mp_pkg;

  // Muller C-element next state: follow the inputs when they agree, else hold.
  function automatic logic c_next(input logic a, input logic b, input logic q);
    return (a == b) ? a : q;
  endfunction

  // A C-element fires when its inputs agree and differ from its state.
  function automatic logic c_fires(input logic a, input logic b, input logic q);
    return (a == b) && (a != q);
  endfunction

endpackage

// File: rtl/mp_celem.sv
module mp_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q,
  output logic fire
);
  import mp_pkg::*;

  assign fire = c_fires(a, b, q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= c_next(a, b, q);
  end
endmodule

// File: rtl/mp_stage.sv
module mp_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_up,
  input  logic              ack_dn,
  input  logic [DATA_W-1:0] d_up,
  output logic              ctl,
  output logic [DATA_W-1:0] d_q
);
  logic fire;

  // Second input is the inverted downstream acknowledge.
  mp_celem u_celem (
    .clk  (clk),
    .rst_n(rst_n),
    .a    (req_up),
    .b    (~ack_dn),
    .q    (ctl),
    .fire (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (fire) d_q <= d_up;
  end
endmodule

// File: rtl/mp_occupancy.sv
module mp_occupancy #(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0] ctl,
  input  logic             tail_ack,
  output logic             empty,
  output logic             full
);
  logic [DEPTH-1:0] held;

  // A stage holds a word while its state differs from the acknowledge it sees.
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_held
      if (g == DEPTH - 1) begin : g_tail
        assign held[g] = ctl[g] ^ tail_ack;
      end else begin : g_mid
        assign held[g] = ctl[g] ^ ctl[g+1];
      end
    end
  endgenerate

  assign empty = ~|held;
  assign full  = &held;
endmodule

// File: rtl/micropipe_ctrl.sv
module micropipe_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data,
  output logic              empty,
  output logic              full
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] ctl;
  logic [DATA_W-1:0] dreg [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      logic              req_w;
      logic              ack_w;
      logic [DATA_W-1:0] din_w;

      if (i == 0) begin : g_head
        assign req_w = in_req;
        assign din_w = in_data;
      end else begin : g_body
        assign req_w = ctl[i-1];
        assign din_w = dreg[i-1];
      end

      if (i == LAST) begin : g_end
        assign ack_w = out_ack;
      end else begin : g_link
        assign ack_w = ctl[i+1];
      end

      mp_stage #(.DATA_W(DATA_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .req_up(req_w),
        .ack_dn(ack_w),
        .d_up  (din_w),
        .ctl   (ctl[i]),
        .d_q   (dreg[i])
      );
    end
  endgenerate

  mp_occupancy #(.DEPTH(DEPTH)) u_occ (
    .ctl     (ctl),
    .tail_ack(out_ack),
    .empty   (empty),
    .full    (full)
  );

  assign in_ack   = ctl[0];
  assign out_req  = ctl[LAST];
  assign out_data = dreg[LAST];
endmodule

// File: rtl/micropipe_ctrl_chk.sv
module micropipe_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_req,
  input logic              in_ack,
  input logic              out_req,
  input logic              out_ack,
  input logic [DATA_W-1:0] out_data,
  input logic              empty,
  input logic              full
);
  AST_IN_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ack) |-> in_ack == $past(in_req)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req != out_ack) |=> ($stable(out_data) && $stable(out_req))); // R7

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_req != in_ack) |=> $stable(in_ack)); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R8

  AST_OUT_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_req) |-> !$past(empty)); // R3

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (!in_ack && !out_req && empty && !full)); // R1
endmodule

bind micropipe_ctrl micropipe_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_req  (in_req),
  .in_ack  (in_ack),
  .out_req (out_req),
  .out_ack (out_ack),
  .out_data(out_data),
  .empty   (empty),
  .full    (full)
);

// File: tb/tb_micropipe_ctrl.sv
module tb_micropipe_ctrl;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int NWORDS = 300;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_req = 1'b0;
  logic              in_ack;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_req;
  logic              out_ack = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic              empty;
  logic              full;

  int checks = 0;
  int errors = 0;
  int tx_cnt = 0;
  int rx_cnt = 0;
  int rx_rise = 0;
  int rx_fall = 0;
  int cons_rate = 0;
  bit cons_en = 1'b0;
  logic [DATA_W-1:0] sbq[$];

  always #2 clk = ~clk;

  micropipe_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .in_data(in_data), .out_req(out_req), .out_ack(out_ack),
    .out_data(out_data), .empty(empty), .full(full)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: offer a word once the previous one is acknowledged.
  task automatic send(input logic [DATA_W-1:0] w);
    while (in_req != in_ack) @(negedge clk);
    sbq.push_back(w);
    in_data = w;
    in_req  = ~in_req;
    tx_cnt++;
    @(negedge clk);
  endtask

  // Monitor: consume at random moments and compare against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cons_en && (out_req != out_ack) && (($urandom % 100) < cons_rate)) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R3 unexpected word", int'(out_data), -1);
      end else begin
        logic [DATA_W-1:0] exp_w;
        exp_w = sbq.pop_front();
        check(out_data == exp_w, "R3/R5 order", int'(out_data), int'(exp_w));
      end
      if (out_ack) rx_fall++; else rx_rise++;
      rx_cnt++;
      out_ack = ~out_ack;
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] first_w;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(in_ack == 0, "R1 in_ack", in_ack, 0);
    check(out_req == 0, "R1 out_req", out_req, 0);
    check(out_data == 0, "R1 out_data", int'(out_data), 0);
    check(empty == 1 && full == 0, "R1 flags", {empty, full}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(empty == 1 && in_ack == 0, "R1 after release", {empty, in_ack}, 2);

    // R4/R2: single word latency with consumer silent
    first_w = 8'hA5;
    sbq.push_back(first_w);
    in_data = first_w;
    in_req = 1'b1;
    tx_cnt++;
    n = 0;
    while (out_req == out_ack && n < 20) begin
      @(negedge clk);
      n++;
      if (n == 1) check(in_ack == in_req, "R2 ack after one clock", in_ack, in_req);
    end
    check(n == DEPTH, "R4 latency", n, DEPTH);
    check(empty == 0, "R8 not empty", empty, 0);

    // R6/R8/R9: fill with output withheld
    for (int k = 1; k < DEPTH; k++) send(DATA_W'(8'h10 + k));
    repeat (DEPTH + 2) @(negedge clk);
    check(full == 1, "R8 full", full, 1);
    check(empty == 0, "R8 empty low when full", empty, 0);
    sbq.push_back(8'h77);
    in_data = 8'h77;
    in_req = ~in_req;
    tx_cnt++;
    repeat (6) @(negedge clk);
    check(in_ack != in_req, "R6 blocked while full", in_ack, int'(~in_req));
    check(out_data == first_w, "R9 head word held", int'(out_data), int'(first_w));

    // R3/R8: drain
    cons_rate = 100;
    cons_en = 1'b1;
    n = 0;
    while ((sbq.size() != 0 || !empty) && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(empty == 1, "R8 empty after drain", empty, 1);
    check(full == 0, "R8 full low after drain", full, 0);

    // R3/R5: random stream
    cons_rate = 50;
    for (int k = 0; k < NWORDS; k++) begin
      repeat ($urandom % 4) @(negedge clk);
      send(DATA_W'($urandom));
    end
    n = 0;
    while ((sbq.size() != 0 || !empty) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(rx_cnt == tx_cnt, "R3 count", rx_cnt, tx_cnt);
    check(rx_rise > 0 && rx_fall > 0, "R5 both edge directions", rx_rise, rx_fall);
    check(empty == 1, "R8 empty at end", empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule